// File: doc/BRIEF.md
# Shift-Add Multiplier Register Datapath

This block holds the registers and arithmetic of an unsigned sequential binary multiplier. It contains a multiplicand register, an accumulator, a multiplier register that fills with the low half of the product, a single carry bit, and an iteration down-counter. It also contains a ripple adder that adds the multiplicand to the accumulator, and a zero detector on the counter. It has no sequencing logic of its own. Each register operation fires only when its own control pin is high, so a separate hardwired controller can step the block one operation at a time.

A typical controller runs a fixed cycle. It loads the operands, then starts the run, which clears the accumulator and carry and presets the counter. It then loops over pairs of cycles. In the first cycle of a pair it adds when the multiplier LSB output is high. In the second it clears the carry and shifts. It leaves the loop when the zero flag is high during a shift cycle. After WIDTH passes, the accumulator and multiplier registers together hold the 2·WIDTH-bit product.

The block has no valid/ready handshake because no data streams through it. The operand inputs are sampled only on a cycle with the operand-load strobe high, and the product bus reflects register contents at all times. Every control pin is a plain level strobe with no back-pressure.

Top module: `sam_datapath`

## Requirements
- R1: After reset, the accumulator, multiplier register, multiplicand register, carry and counter are all zero, so `product_o` is 0, `q_lsb_o` is 0 and `cnt_zero_o` is 1.
- R2: With `ld_operands_i` high, the next edge stores `mcand_i` in the multiplicand register and `mplier_i` in the multiplier register (`product_o[WIDTH-1:0]`). From then on `q_lsb_o` shows bit 0 of that register.
- R3: With `init_i` high, one edge clears the accumulator (`product_o[2*WIDTH-1:WIDTH]`), clears the carry and presets the counter to WIDTH-1.
- R4: With `add_i` high, the next edge writes the low WIDTH bits of accumulator + multiplicand into the accumulator and the adder carry-out into the carry bit. The multiplier register is left unchanged.
- R5: With `shift_i` high, the next edge shifts {carry, accumulator, multiplier register} right by one as one chain. The old carry enters the accumulator MSB, the accumulator LSB enters the multiplier register MSB, the carry becomes 0, and the counter decrements by one.
- R6: `clr_carry_i` alone clears the carry and nothing else. When it is high together with `shift_i`, the carry value from before the edge is shifted into the accumulator MSB, and the carry is 0 afterwards.
- R7: `cnt_zero_o` is 1 exactly when the counter holds 0. After a preset it reads 1 only after WIDTH-1 shifts.
- R8: When strobes collide, the following precedence applies:
  - Accumulator: `init_i` over `add_i` over `shift_i`.
  - Carry: a clear from `init_i` or `clr_carry_i` over `add_i`.
  - Multiplier register: `ld_operands_i` over `shift_i`.
  - Counter: `init_i` over `shift_i`.
- R9: Run the sequence load, init, then pairs of (add if `q_lsb_o`, then clear-carry with shift), ending after the shift in which `cnt_zero_o` was 1. This makes exactly WIDTH pairs and leaves `product_o` equal to `mcand_i * mplier_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mcand_i | input | WIDTH | Multiplicand operand |
| mplier_i | input | WIDTH | Multiplier operand |
| ld_operands_i | input | 1 | Store both operands |
| init_i | input | 1 | Clear accumulator and carry, preset counter |
| add_i | input | 1 | Add multiplicand into accumulator |
| clr_carry_i | input | 1 | Clear carry bit |
| shift_i | input | 1 | Right-shift carry/accumulator/multiplier chain, decrement counter |
| q_lsb_o | output | 1 | Multiplier register bit 0 |
| cnt_zero_o | output | 1 | Counter equals zero |
| product_o | output | 2*WIDTH | {accumulator, multiplier register} |

## Verification
The bound checker looks at every cycle. It checks the one-cycle effect of each strobe: the operand load, the clear and preset, the add with its carry-out, the chain shift with the counter decrement, and the carry clear. Only the bench scenarios can show the whole-run results. These are the correct product over every operand pair of a 4-bit configuration, the exact pass count, and the point where the zero flag rises. The bench also covers the collision cases, where the value shifted in, or an accumulator kept at zero, proves that the precedence and the old-carry rule were applied.

// File: rtl/sam_pkg.sv
package sam_pkg;
  function automatic int cnt_bits(int w);
    return (w <= 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/sam_adder.sv
module sam_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] cy;
  assign cy[0] = 1'b0;
  for (genvar gi = 0; gi < WIDTH; gi++) begin : g_fa
    assign sum_o[gi]  = a_i[gi] ^ b_i[gi] ^ cy[gi];
    assign cy[gi+1]   = (a_i[gi] & b_i[gi]) | (cy[gi] & (a_i[gi] ^ b_i[gi]));
  end
  assign cout_o = cy[WIDTH];
endmodule

// File: rtl/sam_down_cnt.sv
module sam_down_cnt #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          dec_i,
  input  logic [CW-1:0] start_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= start_i;
    else if (dec_i)  cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/sam_zero_det.sv
module sam_zero_det #(
  parameter int CW = 3
) (
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  assign zero_o = ~|val_i;
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  input  logic               ld_operands_i,
  input  logic               init_i,
  input  logic               add_i,
  input  logic               clr_carry_i,
  input  logic               shift_i,
  output logic               q_lsb_o,
  output logic               cnt_zero_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int CW = sam_pkg::cnt_bits(WIDTH);
  localparam logic [CW-1:0] CNT_START = CW'(WIDTH - 1);

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mq_q;
  logic             carry_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] sum;
  logic             sum_cout;

  sam_adder #(.WIDTH(WIDTH)) u_add (
    .a_i(acc_q), .b_i(mcand_q), .sum_o(sum), .cout_o(sum_cout)
  );

  sam_down_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(init_i), .dec_i(shift_i),
    .start_i(CNT_START), .cnt_o(cnt_q)
  );

  sam_zero_det #(.CW(CW)) u_zd (
    .val_i(cnt_q), .zero_o(cnt_zero_o)
  );

  // multiplicand register
  always_ff @(posedge clk) begin
    if (!rst_n)             mcand_q <= '0;
    else if (ld_operands_i) mcand_q <= mcand_i;
  end

  // accumulator: clear > add > shift
  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (init_i)  acc_q <= '0;
    else if (add_i)   acc_q <= sum;
    else if (shift_i) acc_q <= {carry_q, acc_q[WIDTH-1:1]};
  end

  // carry bit: any clear wins over the adder carry-out
  always_ff @(posedge clk) begin
    if (!rst_n)                      carry_q <= 1'b0;
    else if (init_i || clr_carry_i)  carry_q <= 1'b0;
    else if (add_i)                  carry_q <= sum_cout;
    else if (shift_i)                carry_q <= 1'b0;
  end

  // multiplier / low product register
  always_ff @(posedge clk) begin
    if (!rst_n)             mq_q <= '0;
    else if (ld_operands_i) mq_q <= mplier_i;
    else if (shift_i)       mq_q <= {acc_q[0], mq_q[WIDTH-1:1]};
  end

  assign q_lsb_o   = mq_q[0];
  assign product_o = {acc_q, mq_q};
endmodule

// File: rtl/sam_datapath_chk.sv
module sam_datapath_chk #(
  parameter int WIDTH = 8,
  parameter int CW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   mcand_i,
  input logic [WIDTH-1:0]   mplier_i,
  input logic               ld_operands_i,
  input logic               init_i,
  input logic               add_i,
  input logic               clr_carry_i,
  input logic               shift_i,
  input logic               q_lsb_o,
  input logic [2*WIDTH-1:0] product_o,
  input logic [WIDTH-1:0]   mcand_q,
  input logic               carry_q,
  input logic [CW-1:0]      cnt_q
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_operands_i |=> (mcand_q == $past(mcand_i)) && (q_lsb_o == $past(mplier_i[0])));

  a_r3_init: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (product_o[2*WIDTH-1:WIDTH] == '0) && !carry_q && (cnt_q == CW'(WIDTH - 1)));

  a_r4_add: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !init_i && !clr_carry_i && !ld_operands_i && !shift_i) |=>
      ({carry_q, product_o[2*WIDTH-1:WIDTH]} ==
         ($past({1'b0, product_o[2*WIDTH-1:WIDTH]}) + $past({1'b0, mcand_q})))
      && (product_o[WIDTH-1:0] == $past(product_o[WIDTH-1:0])));

  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !init_i && !add_i && !ld_operands_i) |=>
      (product_o == {$past(carry_q), $past(product_o[2*WIDTH-1:1])}) && !carry_q
      && (cnt_q == $past(cnt_q) - 1'b1));

  a_r6_clear_carry: assert property (@(posedge clk) disable iff (!rst_n)
    clr_carry_i |=> !carry_q);
endmodule

bind sam_datapath sam_datapath_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mcand_i(mcand_i), .mplier_i(mplier_i),
  .ld_operands_i(ld_operands_i), .init_i(init_i), .add_i(add_i),
  .clr_carry_i(clr_carry_i), .shift_i(shift_i), .q_lsb_o(q_lsb_o),
  .product_o(product_o), .mcand_q(mcand_q), .carry_q(carry_q), .cnt_q(cnt_q)
);

// File: tb/sam_datapath_bench.sv
module sam_datapath_bench;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] mcand = '0;
  logic [W-1:0] mplier = '0;
  logic ld = 1'b0, init = 1'b0, add = 1'b0, clr = 1'b0, shf = 1'b0;
  logic q_lsb, zflag;
  logic [2*W-1:0] product;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sam_datapath #(.WIDTH(W)) u_sam_datapath (
    .clk(clk), .rst_n(rst_n), .mcand_i(mcand), .mplier_i(mplier),
    .ld_operands_i(ld), .init_i(init), .add_i(add), .clr_carry_i(clr),
    .shift_i(shf), .q_lsb_o(q_lsb), .cnt_zero_o(zflag), .product_o(product)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive strobes for one edge, starting and ending at a falling edge
  task automatic step(input logic l, input logic i, input logic a,
                      input logic c, input logic s);
    ld = l; init = i; add = a; clr = c; shf = s;
    @(negedge clk);
    ld = 0; init = 0; add = 0; clr = 0; shf = 0;
  endtask

  task automatic multiply(input int x, input int y, output int iters);
    logic z;
    mcand = W'(x); mplier = W'(y);
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    iters = 0;
    do begin
      step(0, 0, q_lsb, 0, 0);
      z = zflag;
      step(0, 0, 0, 1, 1);
      iters++;
    end while (!z && iters <= 2*W);
  endtask

  // load B=F, init, two adds: A=E, carry=1
  task automatic make_carry();
    mcand = 4'hF; mplier = 4'h0;
    step(1, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
  endtask

  initial begin
    int it;
    repeat (3) @(negedge clk);
    check("R1 product", int'(product), 0);
    check("R1 q_lsb", int'(q_lsb), 0);
    check("R1 zero flag", int'(zflag), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 load
    mcand = 4'h3; mplier = 4'h9;
    step(1, 0, 0, 0, 0);
    check("R2 multiplier reg", int'(product[W-1:0]), 9);
    check("R2 q_lsb", int'(q_lsb), 1);
    // R3 init, R4 add
    step(0, 1, 0, 0, 0);
    check("R3 zero flag low after preset", int'(zflag), 0);
    step(0, 0, 1, 0, 0);
    check("R4 add result, Q kept", int'(product), 8'h39);
    // R7 counter reaches zero after W-1 shifts
    step(0, 1, 0, 0, 0);
    for (int k = 0; k < W - 2; k++) step(0, 0, 0, 0, 1);
    check("R7 flag low one shift early", int'(zflag), 0);
    step(0, 0, 0, 0, 1);
    check("R7 flag high after W-1 shifts", int'(zflag), 1);

    // R5 shift carries C into A MSB, then zero enters
    make_carry();
    check("R4 carry add", int'(product), 8'hE0);
    step(0, 0, 0, 0, 1);
    check("R5 shift with carry", int'(product), 8'hF0);
    step(0, 0, 0, 0, 1);
    check("R5 zero into carry", int'(product), 8'h78);

    // R6 clear alone
    make_carry();
    step(0, 0, 0, 1, 0);
    check("R6 clear keeps A", int'(product), 8'hE0);
    step(0, 0, 0, 0, 1);
    check("R6 cleared carry shifts 0", int'(product), 8'h70);

    // R6 clear with shift uses old carry
    make_carry();
    step(0, 0, 0, 1, 1);
    check("R6 old carry shifted", int'(product), 8'hF0);
    step(0, 0, 0, 0, 1);
    check("R6 carry zero after", int'(product), 8'h78);

    // R8 precedence
    make_carry();
    step(0, 1, 1, 0, 1);
    check("R8 init over add/shift", int'(product[2*W-1:W]), 0);
    check("R8 counter preset wins", int'(zflag), 0);
    mcand = 4'h5; mplier = 4'hA;
    step(1, 0, 0, 0, 1);
    check("R8 load over shift", int'(product[W-1:0]), 4'hA);

    // R9 exhaustive products
    multiply(13, 11, it);
    check("R9 pass count", it, W);
    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y++) begin
        multiply(x, y, it);
        check($sformatf("R9 %0d*%0d", x, y), int'(product), x * y);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule